// File: doc/BRIEF.md
# Dual-Bank Switch Register File with Shadow Commit

This block holds the register state and command logic for a switch matrix that has two banks of sixteen switches. A byte-wide register bus reaches it. The bus carries an address, write data, a write strobe, a read strobe and registered read data. Each bank keeps a 16-bit live word and a 16-bit shadow word. The live word drives the bank's switch-enable output vector directly. Bit n-1 of a bank word controls switch n, so switch 1 is the least significant bit.

Software can change a bank in two ways. It can write the live bytes directly, and the change takes effect at once. It can also stage a pattern in the shadow bytes and then write a command byte for the bank. A command can close exactly one switch, open every switch, copy both shadow bytes into the live word in one edge so the whole 16-bit output changes together, or leave the bank alone. Reset opens every switch. The reset is asserted asynchronously and released synchronously inside the block.

Top module: `swm_regfile`

## Requirements
- R1: While reset is asserted, and after it is released, every live word, every shadow word and the read data are zero, so every switch is open.
- R2: A write to address 0x00, 0x01, 0x02 or 0x03 replaces, in that order, bank A bits 7:0, bank A bits 15:8, bank B bits 7:0 or bank B bits 15:8 of the live word. The switch output reflects the new value after the clock edge that samples the strobe.
- R3: Addresses 0x10 to 0x13 hold the shadow bytes in the same bank and byte order as R2. They read back what was written. Writing them leaves both switch outputs unchanged.
- R4: Writing a code c in 0 to 15 to the bank A command address 0x14 or the bank B command address 0x15 sets that bank's live word to a single 1 at bit c, opening all other switches of the bank.
- R5: Command code 16 sets the bank's live word to zero.
- R6: Command code 17 loads both shadow bytes of the bank into its live word on one clock edge.
- R7: Command codes 18 to 255 leave the bank's live word unchanged.
- R8: Reads of 0x14, 0x15 and of every unmapped address return 0x00.
- R9: Writes to unmapped addresses change no live or shadow byte.
- R10: A command to one bank leaves the other bank's live word unchanged.
- R11: The read data takes the addressed byte on the edge that samples the read strobe and holds its value while no read is strobed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| sw_a | output | 16 | Bank A live switch enables, bit n-1 is switch n |
| sw_b | output | 16 | Bank B live switch enables, bit n-1 is switch n |

## Verification
The assertions check the following on every cycle:
- the one-hot result of a close command;
- the empty bank after an open command;
- the copy of the previous shadow word after a commit;
- the stability of the live word under shadow writes and no-change codes;
- the zero read-back of the command addresses;
- the holding of the read data.

The following depend on the bench's scenarios:
- the exact byte and bit placement of direct writes;
- the isolation of one bank from the other's commands;
- the ignoring of unmapped writes;
- the clearing of all state by a reset asserted in the middle of a run.

// File: rtl/swm_pkg.sv
package swm_pkg;
  localparam int SW_PER_BANK = 16;
  localparam int N_BANKS     = 2;
  localparam int BYTE_W      = 8;
  localparam int ADDR_W      = 8;
  localparam int BYTES_PER_BANK = SW_PER_BANK / BYTE_W;
  localparam logic [ADDR_W-1:0] LIVE_BASE   = 8'h00;
  localparam logic [ADDR_W-1:0] SHADOW_BASE = 8'h10;
  localparam logic [ADDR_W-1:0] CMD_BASE    = 8'h14;
endpackage

// File: rtl/swm_rst_sync.sv
module swm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/swm_bank.sv
module swm_bank #(
  parameter int W      = swm_pkg::SW_PER_BANK,
  parameter int BYTE_W = swm_pkg::BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W/BYTE_W-1:0] live_we,
  input  logic [W/BYTE_W-1:0] sh_we,
  input  logic              cmd_we,
  input  logic [BYTE_W-1:0] wdata,
  output logic [W-1:0]      live_q,
  output logic [W-1:0]      sh_q
);
  localparam int NB    = W / BYTE_W;
  localparam int SEL_W = $clog2(W);
  localparam logic [BYTE_W-1:0] OPEN_CODE = BYTE_W'(W);
  localparam logic [BYTE_W-1:0] COPY_CODE = BYTE_W'(W + 1);

  logic [W-1:0] live_d, sh_d;
  logic         live_en, sh_en;

  assign live_en = cmd_we | (|live_we);
  assign sh_en   = |sh_we;

  always_comb begin
    live_d = live_q;
    if (cmd_we) begin
      if (wdata < BYTE_W'(W))
        live_d = {{(W-1){1'b0}}, 1'b1} << wdata[SEL_W-1:0];
      else if (wdata == OPEN_CODE)
        live_d = '0;
      else if (wdata == COPY_CODE)
        live_d = sh_q;
    end else begin
      for (int i = 0; i < NB; i++)
        if (live_we[i]) live_d[i*BYTE_W +: BYTE_W] = wdata;
    end
  end

  always_comb begin
    sh_d = sh_q;
    for (int i = 0; i < NB; i++)
      if (sh_we[i]) sh_d[i*BYTE_W +: BYTE_W] = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       live_q <= '0;
    else if (live_en) live_q <= live_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh_q <= '0;
    else if (sh_en) sh_q <= sh_d;
  end

  // R4
  close_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && wdata < BYTE_W'(W)) |=> ($countones(live_q) == 1 && live_q[$past(wdata[SEL_W-1:0])]));
  // R5
  open_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && wdata == OPEN_CODE) |=> (live_q == '0));
  // R6
  copy_shadow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && wdata == COPY_CODE) |=> (live_q == $past(sh_q)));
  // R7
  hold_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && wdata > COPY_CODE) |=> $stable(live_q));
  // R3
  shadow_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|sh_we) && !cmd_we && !(|live_we)) |=> $stable(live_q));
endmodule

// File: rtl/swm_rdmux.sv
module swm_rdmux #(
  parameter int W       = swm_pkg::SW_PER_BANK,
  parameter int BYTE_W  = swm_pkg::BYTE_W,
  parameter int N_BANKS = swm_pkg::N_BANKS,
  parameter int ADDR_W  = swm_pkg::ADDR_W
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic [N_BANKS*W-1:0] live_flat,
  input  logic [N_BANKS*W-1:0] sh_flat,
  output logic [BYTE_W-1:0]    rd_byte
);
  localparam int NB = W / BYTE_W;

  always_comb begin
    rd_byte = '0;
    for (int b = 0; b < N_BANKS; b++) begin
      for (int k = 0; k < NB; k++) begin
        if (addr == ADDR_W'(int'(swm_pkg::LIVE_BASE) + b*NB + k))
          rd_byte = live_flat[(b*NB + k)*BYTE_W +: BYTE_W];
        if (addr == ADDR_W'(int'(swm_pkg::SHADOW_BASE) + b*NB + k))
          rd_byte = sh_flat[(b*NB + k)*BYTE_W +: BYTE_W];
      end
    end
  end
endmodule

// File: rtl/swm_regfile.sv
module swm_regfile #(
  parameter int W      = swm_pkg::SW_PER_BANK,
  parameter int BYTE_W = swm_pkg::BYTE_W,
  parameter int ADDR_W = swm_pkg::ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic [W-1:0]      sw_a,
  output logic [W-1:0]      sw_b
);
  localparam int N_BANKS = swm_pkg::N_BANKS;
  localparam int NB      = W / BYTE_W;

  logic                 rst_sync_n;
  logic [N_BANKS*W-1:0] live_flat, sh_flat;
  logic [BYTE_W-1:0]    rd_byte, rdata_q;

  swm_rst_sync u_rst_sync (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    logic [NB-1:0] live_we, sh_we;
    logic          cmd_we;

    for (genvar k = 0; k < NB; k++) begin : g_byte
      assign live_we[k] = bus_wr &&
        (bus_addr == ADDR_W'(int'(swm_pkg::LIVE_BASE) + b*NB + k));
      assign sh_we[k] = bus_wr &&
        (bus_addr == ADDR_W'(int'(swm_pkg::SHADOW_BASE) + b*NB + k));
    end
    assign cmd_we = bus_wr && (bus_addr == ADDR_W'(int'(swm_pkg::CMD_BASE) + b));

    swm_bank #(.W(W), .BYTE_W(BYTE_W)) u_bank (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .live_we(live_we),
      .sh_we  (sh_we),
      .cmd_we (cmd_we),
      .wdata  (bus_wdata),
      .live_q (live_flat[b*W +: W]),
      .sh_q   (sh_flat[b*W +: W])
    );
  end

  swm_rdmux #(.W(W), .BYTE_W(BYTE_W), .N_BANKS(N_BANKS), .ADDR_W(ADDR_W)) u_rdmux (
    .addr     (bus_addr),
    .live_flat(live_flat),
    .sh_flat  (sh_flat),
    .rd_byte  (rd_byte)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_byte;
  end

  assign bus_rdata = rdata_q;
  assign sw_a      = live_flat[0 +: W];
  assign sw_b      = live_flat[W +: W];

  // R8
  cmd_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_rd && (bus_addr == swm_pkg::CMD_BASE || bus_addr == swm_pkg::CMD_BASE + 8'd1))
    |=> (bus_rdata == '0));
  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !bus_rd |=> $stable(bus_rdata));
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_sync_n |-> (sw_a == '0 && sw_b == '0 && bus_rdata == '0));
endmodule

// File: tb/swm_regfile_bench.sv
module swm_regfile_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0, bus_wdata = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_rdata;
  logic [15:0] sw_a, sw_b;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  swm_regfile u_swm_regfile (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .sw_a(sw_a), .sw_b(sw_b)
  );

  typedef struct packed {
    logic        wr;
    logic        rd;
    logic [7:0]  addr;
    logic [7:0]  data;
    logic [15:0] ea;
    logic [15:0] eb;
    logic [7:0]  erd;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VEC [NV] = '{
    '{1,0,8'h00,8'h81,16'h0081,16'h0000,8'h00,8'd2},  // R2 bank A low byte
    '{1,0,8'h01,8'h40,16'h4081,16'h0000,8'h00,8'd2},  // R2 bank A high byte
    '{1,0,8'h02,8'h0F,16'h4081,16'h000F,8'h00,8'd2},  // R2 bank B low byte
    '{1,0,8'h03,8'hF0,16'h4081,16'hF00F,8'h00,8'd2},  // R2 bank B high byte
    '{0,1,8'h01,8'h00,16'h4081,16'hF00F,8'h40,8'd11}, // R11 read live byte
    '{1,0,8'h10,8'h55,16'h4081,16'hF00F,8'h00,8'd3},  // R3 shadow writes
    '{1,0,8'h11,8'hAA,16'h4081,16'hF00F,8'h00,8'd3},
    '{1,0,8'h12,8'h33,16'h4081,16'hF00F,8'h00,8'd3},
    '{1,0,8'h13,8'hCC,16'h4081,16'hF00F,8'h00,8'd3},
    '{0,1,8'h11,8'h00,16'h4081,16'hF00F,8'hAA,8'd3},  // R3 shadow read-back
    '{1,0,8'h14,8'h05,16'h0020,16'hF00F,8'h00,8'd4},  // R4 close switch 6
    '{1,0,8'h14,8'h0F,16'h8000,16'hF00F,8'h00,8'd4},  // R4 close switch 16
    '{1,0,8'h15,8'h00,16'h8000,16'h0001,8'h00,8'd10}, // R10 B cmd, A untouched
    '{1,0,8'h14,8'h12,16'h8000,16'h0001,8'h00,8'd7},  // R7 code 18
    '{1,0,8'h14,8'hFF,16'h8000,16'h0001,8'h00,8'd7},  // R7 code 255
    '{1,0,8'h14,8'h10,16'h0000,16'h0001,8'h00,8'd5},  // R5 open bank A
    '{1,0,8'h14,8'h11,16'hAA55,16'h0001,8'h00,8'd6},  // R6 commit A
    '{1,0,8'h15,8'h11,16'hAA55,16'hCC33,8'h00,8'd6},  // R6 commit B
    '{0,1,8'h14,8'h00,16'hAA55,16'hCC33,8'h00,8'd8},  // R8 cmd A reads zero
    '{0,1,8'h15,8'h00,16'hAA55,16'hCC33,8'h00,8'd8},  // R8 cmd B reads zero
    '{0,1,8'h20,8'h00,16'hAA55,16'hCC33,8'h00,8'd8},  // R8 unmapped read
    '{1,0,8'h20,8'hFF,16'hAA55,16'hCC33,8'h00,8'd9},  // R9 unmapped write
    '{1,0,8'h04,8'hFF,16'hAA55,16'hCC33,8'h00,8'd9},  // R9
    '{0,1,8'h04,8'h00,16'hAA55,16'hCC33,8'h00,8'd9},  // R9 nothing stored
    '{0,1,8'h03,8'h00,16'hAA55,16'hCC33,8'hCC,8'd2},  // R2 read bank B high
    '{1,0,8'h15,8'h10,16'hAA55,16'h0000,8'h00,8'd5},  // R5 open bank B
    '{1,0,8'h0F,8'h77,16'hAA55,16'h0000,8'h00,8'd9},  // R9 unmapped write
    '{0,1,8'h13,8'h00,16'hAA55,16'h0000,8'hCC,8'd3}   // R3 shadow kept after commit
  };

  task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic rd, input logic [7:0] a, input logic [7:0] d);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
    @(posedge clk); #2;
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  initial begin
    #1;
    chk(1, {sw_a, sw_b}, 32'h0);          // R1 during reset
    chk(1, bus_rdata, 8'h00);
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    chk(1, {sw_a, sw_b}, 32'h0);          // R1 after release
    for (int i = 0; i < NV; i++) begin
      access(VEC[i].wr, VEC[i].rd, VEC[i].addr, VEC[i].data);
      chk(int'(VEC[i].req), sw_a, VEC[i].ea);
      chk(int'(VEC[i].req), sw_b, VEC[i].eb);
      if (VEC[i].rd) chk(int'(VEC[i].req), bus_rdata, VEC[i].erd);
    end
    // R11: read data holds across idle cycles and writes
    access(1'b1, 1'b0, 8'h00, 8'h3C);
    access(1'b0, 1'b1, 8'h00, 8'h00);
    chk(11, bus_rdata, 8'h3C);
    access(1'b0, 1'b0, 8'h00, 8'h00);
    access(1'b1, 1'b0, 8'h00, 8'h99);
    chk(11, bus_rdata, 8'h3C);
    chk(2, sw_a, 16'hAA99);
    // R1: reset mid-run clears live and shadow state
    rst_n = 1'b0;
    #1;
    chk(1, {sw_a, sw_b}, 32'h0);
    chk(1, bus_rdata, 8'h00);
    @(posedge clk); #2 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    access(1'b0, 1'b1, 8'h11, 8'h00);
    chk(1, bus_rdata, 8'h00);
    access(1'b1, 1'b0, 8'h14, 8'h11);     // R6 commit of cleared shadow
    chk(1, sw_a, 16'h0000);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule